// File: doc/BRIEF.md
# Linked-descriptor frame fetcher

This block moves one video frame at a time from memory into a downstream pixel FIFO. Software programs a pointer to a descriptor in memory and sets the enable bit. The block then reads the four-word descriptor, streams the frame's words from the frame buffer in bursts, and follows the descriptor's link to the next frame. A descriptor whose link points back to itself makes the same frame repeat without end.

Each descriptor can ask for a flag at the start and at the end of its frame. Stopping is graceful. A disable request lets the frame in flight finish. After that frame the block fetches no new descriptor, drops its enable and reports that it has stopped through a status bit that software polls. A data burst is issued only when the FIFO has room for the whole burst. The block also records an underrun when the FIFO runs dry while the display is taking pixels.

Top module: `frame_desc_fetch`

## Requirements
- R1: After reset the block issues no memory request and no FIFO push, `enabled` is 0, and `status` is 0.
- R2: Writing the control register (reg_addr 0) with bit 3 set while disabled sets `enabled`. The block then issues one 4-word read at the descriptor pointer (reg_addr 1). The words are taken as next-descriptor address, frame address, frame ID and command, in that order, and `frame_id` shows the ID.
- R3: The command word's low LEN_W bits give the frame length in 32-bit words. Exactly that many words are read from consecutive addresses starting at the frame address, and they are pushed into the FIFO in address order.
- R4: Control bits [29:28] select the data burst length: 0 gives 4 words, 1 gives 8, and 2 or 3 give 16. Every burst is full length except the last one of a frame, which carries only the remaining words.
- R5: After a frame's last word, the block issues a 4-word read at the next-descriptor address. A descriptor that links to itself repeats its frame.
- R6: A data burst request is issued only while `fifo_space` is at least the burst length. Otherwise the block waits, with no request outstanding.
- R7: Status bit 1 is set when a descriptor whose command bit 15 is set has been read. Status bit 2 is set when a frame whose command bit 16 is set has finished. Neither bit is set for a descriptor whose bit is clear.
- R8: Writing control bit 4 while enabled lets the current frame complete. No further descriptor is read, `enabled` clears and status bit 0 sets. Writing bit 4 while disabled sets status bit 0 on the next cycle.
- R9: Writing the status register (reg_addr 2) keeps only the status bits that are 1 in the written value, so writing zero clears every flag.
- R10: Status bit 3 is set when `pix_de` and `fifo_empty` are both high while enabled. The same inputs while disabled leave it clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 descriptor pointer, 2 status |
| reg_wdata | input | 32 | Register write data |
| enabled | output | 1 | Block is enabled |
| status | output | 4 | Flags: 0 stopped, 1 start of frame, 2 end of frame, 3 underrun |
| frame_id | output | 32 | ID word of the most recent descriptor |
| mem_rd_req | output | 1 | Read request valid |
| mem_rd_addr | output | ADDR_W | Read byte address of the first word |
| mem_rd_len | output | 5 | Number of words requested |
| mem_rd_gnt | input | 1 | Request accepted |
| mem_rsp_valid | input | 1 | Read response word valid |
| mem_rsp_data | input | 32 | Read response word |
| fifo_wr | output | 1 | Push a word into the pixel FIFO |
| fifo_wdata | output | 32 | Word pushed |
| fifo_space | input | SPACE_W | Free FIFO entries |
| fifo_empty | input | 1 | FIFO is empty |
| pix_de | input | 1 | Display is consuming pixels |

## Verification
Faults show up directly at the memory port or the FIFO port. A wrong word index during descriptor capture sends the following data request to the wrong address, or gives it the wrong burst length. A bad remaining count makes a frame one word long or short, and the request at the frame's end shows this at once. A lost disable request shows up as an extra descriptor read within a few cycles of the frame's last word. A wrong space comparison shows up as a data request issued while the FIFO is held nearly full.

// File: rtl/fdf_pkg.sv
package fdf_pkg;
   localparam int BLEN_W       = 5;
   localparam int STAT_W       = 4;
   localparam int CTRL_EN      = 3;
   localparam int CTRL_DIS     = 4;
   localparam int CTRL_BSEL_LO = 28;
   localparam int CMD_SOF      = 15;
   localparam int CMD_EOF      = 16;
   localparam int ST_STOP      = 0;
   localparam int ST_SOF       = 1;
   localparam int ST_EOF       = 2;
   localparam int ST_UNDR      = 3;

   typedef enum logic [2:0] {
      S_IDLE, S_DREQ, S_DRSP, S_BREQ, S_BRSP, S_END
   } walk_state_e;

   typedef enum logic [1:0] {
      REG_CTRL = 2'd0, REG_DESC = 2'd1, REG_STAT = 2'd2
   } reg_sel_e;

   function automatic logic [BLEN_W-1:0] burst_words(input logic [1:0] sel);
      case (sel)
         2'd0:    return BLEN_W'(4);
         2'd1:    return BLEN_W'(8);
         default: return BLEN_W'(16);
      endcase
   endfunction
endpackage

// File: rtl/fdf_regs.sv
module fdf_regs
   import fdf_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_we,
   input  logic [1:0]            reg_addr,
   input  logic [31:0]           reg_wdata,
   input  logic                  sof_pulse,
   input  logic                  eof_pulse,
   input  logic                  stop_done,
   input  logic                  fifo_empty,
   input  logic                  pix_de,
   output logic                  start,
   output logic                  stop_req,
   output logic [1:0]            burst_sel,
   output logic [ADDR_W-1:0]     desc_base,
   output logic                  enabled,
   output logic [STAT_W-1:0]     status
);
   logic wr_ctrl, wr_desc, wr_stat;
   logic [STAT_W-1:0] set_bits, keep_mask;

   assign wr_ctrl = reg_we && (reg_addr == REG_CTRL);
   assign wr_desc = reg_we && (reg_addr == REG_DESC);
   assign wr_stat = reg_we && (reg_addr == REG_STAT);
   assign start   = wr_ctrl && reg_wdata[CTRL_EN] && !enabled;

   always_comb begin
      set_bits          = '0;
      set_bits[ST_SOF]  = sof_pulse;
      set_bits[ST_EOF]  = eof_pulse;
      set_bits[ST_UNDR] = enabled && pix_de && fifo_empty;
      set_bits[ST_STOP] = stop_done || (wr_ctrl && reg_wdata[CTRL_DIS] && !enabled);
      keep_mask         = wr_stat ? reg_wdata[STAT_W-1:0] : '1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enabled   <= 1'b0;
         stop_req  <= 1'b0;
         burst_sel <= 2'd0;
         desc_base <= '0;
         status    <= '0;
      end else begin
         status <= (status & keep_mask) | set_bits;
         if (wr_desc) desc_base <= reg_wdata[ADDR_W-1:0];
         if (wr_ctrl) burst_sel <= reg_wdata[CTRL_BSEL_LO +: 2];
         if (start) enabled <= 1'b1;
         if (wr_ctrl && reg_wdata[CTRL_DIS] && enabled) stop_req <= 1'b1;
         if (stop_done) begin
            enabled  <= 1'b0;
            stop_req <= 1'b0;
         end
      end
   end

   // R8: finishing the last frame drops enable and reports the stop
   a_r8_stop_clears_enable: assert property (@(posedge clk) disable iff (!rst_n)
      stop_done |=> (!enabled && status[ST_STOP]));

   // R10: an underrun flag only ever rises out of an enabled cycle
   a_r10_underrun_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[ST_UNDR]) |-> $past(enabled));
endmodule

// File: rtl/fdf_walker.sv
module fdf_walker
   import fdf_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int LEN_W   = 12,
   parameter int SPACE_W = 6,
   parameter bit HOLD_ID = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  stop_req,
   input  logic [1:0]            burst_sel,
   input  logic [ADDR_W-1:0]     desc_base,
   output logic                  mem_rd_req,
   output logic [ADDR_W-1:0]     mem_rd_addr,
   output logic [BLEN_W-1:0]     mem_rd_len,
   input  logic                  mem_rd_gnt,
   input  logic                  mem_rsp_valid,
   input  logic [31:0]           mem_rsp_data,
   output logic                  fifo_wr,
   output logic [31:0]           fifo_wdata,
   input  logic [SPACE_W-1:0]    fifo_space,
   output logic                  sof_pulse,
   output logic                  eof_pulse,
   output logic                  stop_done,
   output logic [31:0]           frame_id
);
   walk_state_e        state;
   logic [ADDR_W-1:0]  desc_ptr, nxt_ptr, fr_addr;
   logic [LEN_W-1:0]   remain, cmd_len;
   logic [BLEN_W-1:0]  beat_left, bwords, blen;
   logic [1:0]         widx;
   logic               want_eof, room, last_word;

   assign bwords    = burst_words(burst_sel);
   assign blen      = (remain < LEN_W'(bwords)) ? BLEN_W'(remain) : bwords;
   assign room      = 32'(fifo_space) >= 32'(blen);
   assign cmd_len   = mem_rsp_data[LEN_W-1:0];
   assign last_word = (state == S_DRSP) && mem_rsp_valid && (widx == 2'd3);

   assign mem_rd_req  = (state == S_DREQ) || ((state == S_BREQ) && room);
   assign mem_rd_addr = (state == S_DREQ) ? desc_ptr : fr_addr;
   assign mem_rd_len  = (state == S_DREQ) ? BLEN_W'(4) : blen;
   assign fifo_wr     = (state == S_BRSP) && mem_rsp_valid;
   assign fifo_wdata  = mem_rsp_data;
   assign sof_pulse   = last_word && mem_rsp_data[CMD_SOF];
   assign eof_pulse   = (state == S_END) && want_eof;
   assign stop_done   = (state == S_END) && stop_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         desc_ptr  <= '0;
         nxt_ptr   <= '0;
         fr_addr   <= '0;
         remain    <= '0;
         beat_left <= '0;
         widx      <= '0;
         want_eof  <= 1'b0;
      end else begin
         case (state)
            S_IDLE: if (start) begin
               desc_ptr <= desc_base;
               state    <= S_DREQ;
            end
            S_DREQ: if (mem_rd_req && mem_rd_gnt) begin
               widx  <= '0;
               state <= S_DRSP;
            end
            S_DRSP: if (mem_rsp_valid) begin
               widx <= widx + 2'd1;
               case (widx)
                  2'd0: nxt_ptr <= mem_rsp_data[ADDR_W-1:0];
                  2'd1: fr_addr <= mem_rsp_data[ADDR_W-1:0];
                  2'd3: begin
                     remain   <= cmd_len;
                     want_eof <= mem_rsp_data[CMD_EOF];
                     state    <= (cmd_len == '0) ? S_END : S_BREQ;
                  end
                  default: ;
               endcase
            end
            S_BREQ: if (mem_rd_req && mem_rd_gnt) begin
               beat_left <= blen;
               state     <= S_BRSP;
            end
            S_BRSP: if (mem_rsp_valid) begin
               fr_addr   <= fr_addr + ADDR_W'(4);
               remain    <= remain - LEN_W'(1);
               beat_left <= beat_left - BLEN_W'(1);
               if (beat_left == BLEN_W'(1))
                  state <= (remain == LEN_W'(1)) ? S_END : S_BREQ;
            end
            S_END: begin
               if (stop_req) state <= S_IDLE;
               else begin
                  desc_ptr <= nxt_ptr;
                  state    <= S_DREQ;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   generate
      if (HOLD_ID) begin : g_id_reg
         logic [31:0] id_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) id_q <= '0;
            else if ((state == S_DRSP) && mem_rsp_valid && (widx == 2'd2)) id_q <= mem_rsp_data;
         end
         assign frame_id = id_q;
      end else begin : g_id_none
         assign frame_id = '0;
      end
   endgenerate

   // R4: every request asks for between one and sixteen words
   a_r4_len_range: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> ((mem_rd_len != '0) && (mem_rd_len <= BLEN_W'(16))));

   // R6: a data burst never asks for more words than the FIFO can hold
   a_r6_room_for_burst: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == S_BREQ) && mem_rd_req) |-> (32'(fifo_space) >= 32'(mem_rd_len)));

   // R3: responses never overlap a new request (one transfer outstanding)
   a_r3_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid |-> !mem_rd_req);
endmodule

// File: rtl/frame_desc_fetch.sv
module frame_desc_fetch
   import fdf_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int LEN_W   = 12,
   parameter int SPACE_W = 6,
   parameter bit HOLD_ID = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_we,
   input  logic [1:0]            reg_addr,
   input  logic [31:0]           reg_wdata,
   output logic                  enabled,
   output logic [STAT_W-1:0]     status,
   output logic [31:0]           frame_id,
   output logic                  mem_rd_req,
   output logic [ADDR_W-1:0]     mem_rd_addr,
   output logic [BLEN_W-1:0]     mem_rd_len,
   input  logic                  mem_rd_gnt,
   input  logic                  mem_rsp_valid,
   input  logic [31:0]           mem_rsp_data,
   output logic                  fifo_wr,
   output logic [31:0]           fifo_wdata,
   input  logic [SPACE_W-1:0]    fifo_space,
   input  logic                  fifo_empty,
   input  logic                  pix_de
);
   generate
      if (LEN_W < BLEN_W || LEN_W > CMD_SOF) begin : g_bad_len
         $error("LEN_W must lie between 5 and 15");
      end
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
         $error("ADDR_W must lie between 8 and 32");
      end
      if ((2 ** SPACE_W) - 1 < 16) begin : g_bad_space
         $error("SPACE_W too small to report room for a 16-word burst");
      end
   endgenerate

   logic              start, stop_req, sof_pulse, eof_pulse, stop_done;
   logic [1:0]        burst_sel;
   logic [ADDR_W-1:0] desc_base;

   fdf_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .sof_pulse(sof_pulse), .eof_pulse(eof_pulse),
      .stop_done(stop_done), .fifo_empty(fifo_empty), .pix_de(pix_de),
      .start(start), .stop_req(stop_req), .burst_sel(burst_sel),
      .desc_base(desc_base), .enabled(enabled), .status(status)
   );

   fdf_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SPACE_W(SPACE_W), .HOLD_ID(HOLD_ID)) u_walker (
      .clk(clk), .rst_n(rst_n), .start(start), .stop_req(stop_req),
      .burst_sel(burst_sel), .desc_base(desc_base),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_len(mem_rd_len),
      .mem_rd_gnt(mem_rd_gnt), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .fifo_space(fifo_space),
      .sof_pulse(sof_pulse), .eof_pulse(eof_pulse), .stop_done(stop_done),
      .frame_id(frame_id)
   );
endmodule

// File: tb/frame_desc_fetch_bench.sv
module frame_desc_fetch_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic        enabled;
   logic [3:0]  status;
   logic [31:0] frame_id;
   logic        mem_rd_req;
   logic [31:0] mem_rd_addr;
   logic [4:0]  mem_rd_len;
   logic        mem_rd_gnt;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_data;
   logic        fifo_wr;
   logic [31:0] fifo_wdata;
   logic [5:0]  fifo_space = 6'd63;
   logic        fifo_empty = 1'b0;
   logic        pix_de = 1'b0;

   always #2 clk = ~clk;

   frame_desc_fetch u_frame_desc_fetch (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .enabled(enabled), .status(status), .frame_id(frame_id),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_len(mem_rd_len),
      .mem_rd_gnt(mem_rd_gnt), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .fifo_space(fifo_space),
      .fifo_empty(fifo_empty), .pix_de(pix_de)
   );

   // memory model
   logic [31:0] mem [0:255];
   logic [31:0] raddr;
   logic [4:0]  rcnt;
   assign mem_rd_gnt = mem_rd_req && (rcnt == 5'd0);

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rcnt <= '0; raddr <= '0; mem_rsp_valid <= 1'b0; mem_rsp_data <= '0;
      end else begin
         if (rcnt != 5'd0) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem[raddr[9:2]];
            raddr         <= raddr + 32'd4;
            rcnt          <= rcnt - 5'd1;
         end else mem_rsp_valid <= 1'b0;
         if (mem_rd_req && mem_rd_gnt) begin
            raddr <= mem_rd_addr;
            rcnt  <= mem_rd_len;
         end
      end
   end

   int n_checks = 0, n_fail = 0, words_seen = 0, reqs_seen = 0;
   bit reported = 1'b0;
   logic [31:0] exp_w[$];
   logic [36:0] exp_r[$];

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && mem_rd_req && mem_rd_gnt) begin
         reqs_seen++;
         if (exp_r.size() == 0) chk(1'b0, "R5 unexpected request", {27'd0, mem_rd_addr, mem_rd_len}, 64'd0);
         else begin
            logic [36:0] e;
            e = exp_r.pop_front();
            chk({mem_rd_addr, mem_rd_len} == e, "R4 request addr/len", {27'd0, mem_rd_addr, mem_rd_len}, {27'd0, e});
         end
      end
      if (rst_n && fifo_wr) begin
         words_seen++;
         if (exp_w.size() == 0) chk(1'b0, "R3 unexpected push", {32'd0, fifo_wdata}, 64'd0);
         else begin
            logic [31:0] w;
            w = exp_w.pop_front();
            chk(fifo_wdata == w, "R3 pushed word", {32'd0, fifo_wdata}, {32'd0, w});
         end
      end
   end

   task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic set_desc(input int at, input logic [31:0] nx, input logic [31:0] fa,
                           input logic [31:0] id, input logic [31:0] cmd);
      mem[at/4] = nx; mem[at/4+1] = fa; mem[at/4+2] = id; mem[at/4+3] = cmd;
   endtask

   // driver: expected requests and words of one frame
   task automatic push_frame(input logic [31:0] da, input logic [31:0] fa, input int len, input int bsz);
      int left = len;
      logic [31:0] a = fa;
      exp_r.push_back({da, 5'd4});
      while (left > 0) begin
         int n = (left < bsz) ? left : bsz;
         exp_r.push_back({a, 5'(n)});
         for (int k = 0; k < n; k++) exp_w.push_back(mem[(a / 4 + k) % 256]);
         a = a + 32'(4 * n);
         left = left - n;
      end
   endtask

   task automatic finish_stop();
      wait (enabled == 1'b0);
      repeat (6) @(negedge clk);
      chk(exp_r.size() == 0 && exp_w.size() == 0, "R5 all expected traffic seen", 64'(exp_r.size() + exp_w.size()), 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "watchdog expired", 64'd0, 64'd1);
      report();
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 | 32'(i * 7);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!mem_rd_req && !fifo_wr, "R1 idle outputs", {62'd0, mem_rd_req, fifo_wr}, 64'd0);
      chk(enabled == 1'b0, "R1 enabled", 64'(enabled), 64'd0);
      chk(status == 4'd0, "R1 status", 64'(status), 64'd0);

      // Test A: burst 4, short last burst, SOF+EOF, disable at once
      set_desc(32'h40, 32'h80, 32'h200, 32'h11, 32'd10 | (32'd1 << 15) | (32'd1 << 16));
      push_frame(32'h40, 32'h200, 10, 4);
      wr_reg(2'd1, 32'h40);
      wr_reg(2'd0, 32'h8);
      chk(enabled == 1'b1, "R2 enable set", 64'(enabled), 64'd1);
      wr_reg(2'd0, 32'h10);
      finish_stop();
      chk(frame_id == 32'h11, "R2 frame id", 64'(frame_id), 64'h11);
      chk(status == 4'b0111, "R7 R8 status after frame A", 64'(status), 64'h7);

      // R9: partial and full clear
      wr_reg(2'd2, 32'h6);
      chk(status == 4'b0110, "R9 masked clear", 64'(status), 64'h6);
      wr_reg(2'd2, 32'h0);
      chk(status == 4'b0000, "R9 clear by zero", 64'(status), 64'h0);

      // Test B: burst 8, two linked descriptors, stop during second
      begin
         int base;
         set_desc(32'h80, 32'hC0, 32'h300, 32'h22, 32'd12);
         set_desc(32'hC0, 32'h80, 32'h340, 32'h33, 32'd5 | (32'd1 << 16));
         push_frame(32'h80, 32'h300, 12, 8);
         push_frame(32'hC0, 32'h340, 5, 8);
         base = words_seen;
         wr_reg(2'd1, 32'h80);
         wr_reg(2'd0, 32'h1000_0008);
         wait (words_seen == base + 13);
         wr_reg(2'd0, 32'h1000_0010);
         finish_stop();
         chk(frame_id == 32'h33, "R5 followed next pointer", 64'(frame_id), 64'h33);
         chk(status == 4'b0101, "R7 EOF only, R8 stopped", 64'(status), 64'h5);
      end

      // Test C: self-linked descriptor, burst select 3 (16 words), three frames
      wr_reg(2'd2, 32'h0);
      begin
         int base;
         set_desc(32'h100, 32'h100, 32'h380, 32'h44, 32'd20 | (32'd1 << 15));
         for (int f = 0; f < 3; f++) push_frame(32'h100, 32'h380, 20, 16);
         base = words_seen;
         wr_reg(2'd1, 32'h100);
         wr_reg(2'd0, 32'h3000_0008);
         wait (words_seen == base + 42);
         wr_reg(2'd0, 32'h3000_0010);
         finish_stop();
         chk(status == 4'b0011, "R7 SOF only, R5 repeat stopped", 64'(status), 64'h3);
         chk(words_seen == base + 60, "R5 three repeated frames", 64'(words_seen - base), 64'd60);
      end

      // Test D: stall on FIFO space, underrun, disable while stalled
      wr_reg(2'd2, 32'h0);
      @(negedge clk);
      pix_de = 1'b1; fifo_empty = 1'b1;
      repeat (3) @(negedge clk);
      pix_de = 1'b0; fifo_empty = 1'b0;
      @(negedge clk);
      chk(status[3] == 1'b0, "R10 underrun ignored while disabled", 64'(status), 64'h0);
      begin
         int rbase;
         set_desc(32'h140, 32'h140, 32'h200, 32'h55, 32'd6);
         push_frame(32'h140, 32'h200, 6, 4);
         fifo_space = 6'd3;
         rbase = reqs_seen;
         wr_reg(2'd1, 32'h140);
         wr_reg(2'd0, 32'h0000_0008);
         repeat (30) @(negedge clk);
         chk(reqs_seen == rbase + 1, "R6 data request held back", 64'(reqs_seen - rbase), 64'd1);
         chk(!mem_rd_req, "R6 no request while short of space", 64'(mem_rd_req), 64'd0);
         pix_de = 1'b1; fifo_empty = 1'b1;
         @(negedge clk);
         pix_de = 1'b0; fifo_empty = 1'b0;
         @(negedge clk);
         chk(status[3] == 1'b1, "R10 underrun while enabled", 64'(status), 64'h8);
         wr_reg(2'd0, 32'h0000_0010);
         fifo_space = 6'd63;
         finish_stop();
         chk(status == 4'b1001, "R8 stop after stalled frame", 64'(status), 64'h9);
      end

      // R8: disable while already disabled
      wr_reg(2'd2, 32'h0);
      wr_reg(2'd0, 32'h0000_0010);
      chk(status == 4'b0001, "R8 idle disable reports stop", 64'(status), 64'h1);
      chk(enabled == 1'b0, "R8 stays disabled", 64'(enabled), 64'd0);

      report();
      $finish;
   end
endmodule